// File: doc/BRIEF.md
# Delay-Locked Loop Bring-Up Sequencer

This block powers up a clock-tracking delay-locked loop after the card clock has been retuned. It owns a 32-bit configuration image that feeds the loop, records the most recent clock frequency it was told about, and runs only when that frequency has really changed to a value above 52 MHz. Once a run starts, it writes the image in three fixed steps with a 1 ms settle gap after each one. It then samples the lock flag of the loop's status word every 2 ms until the flag is seen or a 1 s budget is used up.

Requests arrive as a one-cycle pulse on `req_valid` with the new frequency on `req_hz`. The pulse has no ready and no back-pressure. A pulse that arrives while `busy` is high is dropped as if it never happened. Each write step is a read-modify-write of the held image, so the only bits that change are the ones that step names. All gaps are counters derived from the `CLK_HZ` parameter, and a bench may scale that parameter down. When a run ends, `done` rises together with exactly one of `locked` or `timeout_error`. These outputs hold until the next run is accepted.

Top module: `dll_lock_seq`

## Requirements
- R1: Out of reset, `dll_cfg` equals the `CFG_RESET` parameter, and `busy`, `done`, `locked` and `timeout_error` are all low.
- R2: A request is accepted only while `busy` is low. An accepted request starts a run only if `req_hz` differs from the recorded frequency and is strictly greater than `THRESH_HZ` (default 52,000,000). The recorded frequency resets to 0 and takes `req_hz` on every accepted request. A request that does not start a run leaves `dll_cfg` and all flags untouched.
- R3: On the clock edge that accepts a starting request, `busy` rises and `dll_cfg` clears bit 21 (loop enable) and bits 18, 24, 25, 26 and 27 (compensation enables). All other bits are kept.
- R4: SETTLE cycles after that edge, `dll_cfg` ORs in bits 27:24, 18, 16 (search mode), 11:10 (the 0xC00 start count) and 1:0 (phase value 3). All other bits are kept. SETTLE equals CLK_HZ/1000 cycles, or 1 if that is smaller.
- R5: SETTLE cycles after the R4 write, `dll_cfg` sets bit 21. All other bits are kept.
- R6: The first lock sample is taken 3·SETTLE+1 cycles after the accepting edge, and further samples follow every POLL cycles (POLL = CLK_HZ/500). Only bit 18 of `lock_status` counts as lock.
- R7: On a sample that sees the lock bit, `done` and `locked` rise and `busy` falls, all on that same edge.
- R8: If NUM_POLLS samples (500 poll periods plus the first sample, 501 in all) all miss, then on the last one `done` and `timeout_error` rise and `busy` falls. A lock seen on that last sample gives `locked`, not a timeout.
- R9: A request whose edge falls while `busy` is high, including the edge on which a run ends, is dropped. It starts nothing and does not change the recorded frequency.
- R10: An accepted start clears `done`, `locked` and `timeout_error` on its own edge. The image carries over from one run to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle pulse announcing a new card clock |
| req_hz | input | 32 | New card clock frequency in Hz |
| lock_status | input | 32 | Status word of the loop; bit 18 is lock |
| dll_cfg | output | 32 | Configuration image driven to the loop |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |
| locked | output | 1 | The last run ended with lock seen |
| timeout_error | output | 1 | The last run ran out of polls |

## Verification
Two events can meet on one edge, and each pair is forced in the bench. The first pair is a lock sample and the end of the poll budget. The bench raises the lock bit just before the 501st sample, and the run must report `locked` with no timeout. The second pair is a fresh request and the edge that ends a run. The bench pulses `req_valid` into exactly the edge where `done` rises, then requests the same frequency again. The scoreboard must see no new image write from the first pulse, and the second pulse must start a run, which proves the dropped request did not alter the recorded frequency.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;

  localparam logic [31:0] CFG_EN_MASK     = 32'h0020_0000; // loop enable, bit 21
  localparam logic [31:0] CFG_CPST_MASK   = 32'h0F04_0000; // bits 27:24 and 18
  localparam logic [31:0] CFG_SEARCH_MASK = 32'h0001_0000; // bit 16
  localparam logic [31:0] CFG_COUNT_BITS  = 32'h0000_0C00; // start count
  localparam logic [31:0] CFG_PHASE_BITS  = 32'h0000_0003; // phase value
  localparam logic [31:0] STAT_LOCK_MASK  = 32'h0004_0000; // status bit 18

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_QUIET = 2'd1,
    OP_PREP  = 2'd2,
    OP_ARM   = 2'd3
  } cfg_op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_QUIET  = 3'd1,
    ST_PREP   = 3'd2,
    ST_ARM    = 3'd3,
    ST_POLL   = 3'd4
  } seq_state_e;

endpackage

// File: rtl/dll_req_filter.sv
module dll_req_filter #(
  parameter int unsigned THRESH_HZ = 32'd52_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_hz,
  input  logic        accept_ok,
  output logic        start
);

  logic [31:0] last_hz_q;
  logic        take;

  assign take  = req_valid && accept_ok;
  assign start = take && (req_hz != last_hz_q) && (req_hz > THRESH_HZ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      last_hz_q <= '0;
    else if (take)
      last_hz_q <= req_hz;
  end

endmodule

// File: rtl/dll_gap_timer.sv
module dll_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dll_cfg_image.sv
module dll_cfg_image
  import dll_seq_pkg::*;
#(
  parameter logic [31:0] CFG_RESET = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  cfg_op_e     op,
  output logic [31:0] image
);

  logic [31:0] img_q;
  logic [31:0] img_d;

  always_comb begin
    unique case (op)
      OP_QUIET: img_d = img_q & ~(CFG_EN_MASK | CFG_CPST_MASK);
      OP_PREP:  img_d = img_q | CFG_CPST_MASK | CFG_SEARCH_MASK
                              | CFG_COUNT_BITS | CFG_PHASE_BITS;
      OP_ARM:   img_d = img_q | CFG_EN_MASK;
      default:  img_d = img_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      img_q <= CFG_RESET;
    else
      img_q <= img_d;
  end

  assign image = img_q;

endmodule

// File: rtl/dll_lock_seq.sv
module dll_lock_seq
  import dll_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 200_000_000,
  parameter int unsigned THRESH_HZ  = 32'd52_000_000,
  parameter int unsigned SETTLE_US  = 1000,
  parameter int unsigned POLL_US    = 2000,
  parameter int unsigned BUDGET_US  = 1_000_000,
  parameter logic [31:0] CFG_RESET  = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_hz,
  input  logic [31:0] lock_status,
  output logic [31:0] dll_cfg,
  output logic        busy,
  output logic        done,
  output logic        locked,
  output logic        timeout_error
);

  localparam longint SETTLE_RAW = (longint'(CLK_HZ) * longint'(SETTLE_US)) / 64'd1_000_000;
  localparam longint POLL_RAW   = (longint'(CLK_HZ) * longint'(POLL_US)) / 64'd1_000_000;
  localparam int     SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : int'(SETTLE_RAW);
  localparam int     POLL_CYC   = (POLL_RAW < 1) ? 1 : int'(POLL_RAW);
  localparam int     NUM_POLLS  = int'(BUDGET_US / POLL_US) + 1;
  localparam int     TMR_MAX    = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int     TMR_W      = $clog2(TMR_MAX + 1);
  localparam int     PCNT_W     = $clog2(NUM_POLLS + 1);
  localparam logic [TMR_W-1:0]  SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0]  POLL_LD   = TMR_W'(POLL_CYC - 1);
  localparam logic [PCNT_W-1:0] LAST_POLL = PCNT_W'(NUM_POLLS - 1);

  seq_state_e        state_q, state_d;
  cfg_op_e           op;
  logic              start;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic [PCNT_W-1:0] pcnt_q;
  logic              lock_hit;
  logic              last_poll;
  logic              done_q, locked_q, tmo_q;

  assign busy      = (state_q != ST_IDLE);
  assign lock_hit  = |(lock_status & STAT_LOCK_MASK);
  assign last_poll = (pcnt_q == LAST_POLL);

  dll_req_filter #(.THRESH_HZ(THRESH_HZ)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_hz    (req_hz),
    .accept_ok (!busy),
    .start     (start)
  );

  dll_gap_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  dll_cfg_image #(.CFG_RESET(CFG_RESET)) u_image (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .image (dll_cfg)
  );

  always_comb begin
    state_d  = state_q;
    op       = OP_HOLD;
    tmr_load = 1'b0;
    tmr_val  = SETTLE_LD;
    unique case (state_q)
      ST_IDLE: if (start) begin
        op       = OP_QUIET;
        tmr_load = 1'b1;
        state_d  = ST_QUIET;
      end
      ST_QUIET: if (tmr_zero) begin
        op       = OP_PREP;
        tmr_load = 1'b1;
        state_d  = ST_PREP;
      end
      ST_PREP: if (tmr_zero) begin
        op       = OP_ARM;
        tmr_load = 1'b1;
        state_d  = ST_ARM;
      end
      ST_ARM: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = '0;
        state_d  = ST_POLL;
      end
      ST_POLL: if (tmr_zero) begin
        if (lock_hit || last_poll) begin
          state_d = ST_IDLE;
        end else begin
          tmr_load = 1'b1;
          tmr_val  = POLL_LD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pcnt_q   <= '0;
      done_q   <= 1'b0;
      locked_q <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start) begin
        done_q   <= 1'b0;
        locked_q <= 1'b0;
        tmo_q    <= 1'b0;
        pcnt_q   <= '0;
      end else if (state_q == ST_POLL && tmr_zero) begin
        if (lock_hit) begin
          done_q   <= 1'b1;
          locked_q <= 1'b1;
        end else if (last_poll) begin
          done_q <= 1'b1;
          tmo_q  <= 1'b1;
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
    end
  end

  assign done          = done_q;
  assign locked        = locked_q;
  assign timeout_error = tmo_q;

endmodule

// File: rtl/dll_lock_seq_chk.sv
module dll_lock_seq_chk
  import dll_seq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] lock_status,
  input logic [31:0] dll_cfg,
  input logic        busy,
  input logic        done,
  input logic        locked,
  input logic        timeout_error
);

  localparam logic [31:0] PREP_SET = CFG_CPST_MASK | CFG_SEARCH_MASK;

  AST_START_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ((dll_cfg & (CFG_EN_MASK | CFG_CPST_MASK)) == 32'h0)); // R3

  AST_ENABLE_AFTER_PREP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_cfg[21]) |-> (busy && ((dll_cfg & PREP_SET) == PREP_SET))); // R5

  AST_IDLE_IMAGE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(dll_cfg)); // R2

  AST_DONE_IMPLIES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7

  AST_LOCK_FROM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(lock_status[18])); // R6

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && timeout_error)); // R8

  AST_OUTCOME_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked || timeout_error) |-> done); // R10

endmodule

bind dll_lock_seq dll_lock_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lock_status   (lock_status),
  .dll_cfg       (dll_cfg),
  .busy          (busy),
  .done          (done),
  .locked        (locked),
  .timeout_error (timeout_error)
);

// File: tb/tb_dll_lock_seq.sv
module tb_dll_lock_seq;

  localparam int unsigned CLK_HZ = 20_000;
  localparam longint S   = 20;   // settle cycles
  localparam longint P   = 40;   // poll cycles
  localparam longint NP  = 501;  // samples in the budget
  localparam logic [31:0] RST_IMG  = 32'h4220_5A00;
  localparam logic [31:0] M_EN     = 32'h0020_0000;
  localparam logic [31:0] M_CPST   = 32'h0F04_0000;
  localparam logic [31:0] M_PREP   = 32'h0F04_0000 | 32'h0001_0000 | 32'h0000_0C00 | 32'h0000_0003;
  localparam logic [31:0] LOCKBIT  = 32'h0004_0000;
  localparam longint NEVER = 64'd1 << 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_hz = '0;
  logic [31:0] lock_status = ~LOCKBIT;
  logic [31:0] dll_cfg;
  logic        busy, done, locked, timeout_error;

  always #2.5 clk = ~clk;

  dll_lock_seq #(.CLK_HZ(CLK_HZ), .CFG_RESET(RST_IMG)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hz(req_hz),
    .lock_status(lock_status), .dll_cfg(dll_cfg), .busy(busy), .done(done),
    .locked(locked), .timeout_error(timeout_error)
  );

  typedef struct {
    int          kind;   // 0 image write, 1 outcome {locked,timeout}
    logic [31:0] val;
    longint      cyc;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          errors = 0;
  longint      cyc = 0;
  longint      lock_cyc = NEVER;
  logic [31:0] img = RST_IMG;
  logic [31:0] prev_cfg = RST_IMG;
  logic        prev_done = 1'b0;
  bit          finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // status word: all bits but lock set until the planned lock cycle
  always @(negedge clk) lock_status = (cyc >= lock_cyc) ? (~LOCKBIT | LOCKBIT) : ~LOCKBIT;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic pop_cmp(input int kind, input logic [31:0] val);
    exp_t e;
    if (q.size() == 0) begin
      chk(0, (kind == 0) ? "R2 unexpected image write" : "R9 unexpected completion", val, 32'h0);
    end else begin
      e = q.pop_front();
      chk(e.kind == kind && e.val == val, e.tag, val, e.val);
      chk(e.cyc == cyc, {e.tag, " timing"}, 32'(cyc), 32'(e.cyc));
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (dll_cfg !== prev_cfg) pop_cmp(0, dll_cfg);
      if (done && !prev_done)   pop_cmp(1, {30'b0, locked, timeout_error});
      prev_cfg  = dll_cfg;
      prev_done = done;
    end
  end

  // driver: push expectations, then issue the request (and an optional extra one)
  task automatic run_seq(input logic [31:0] hz, input longint k, input bit to,
                         input logic [31:0] xhz, input longint xoff);
    longint c0, dcyc;
    @(negedge clk);
    c0 = cyc + 1;
    img = img & ~(M_EN | M_CPST);
    q.push_back('{0, img, c0, "R3 quiet step"});
    img = img | M_PREP;
    q.push_back('{0, img, c0 + S, "R4 prepare step"});
    img = img | M_EN;
    q.push_back('{0, img, c0 + 2*S, "R5 enable step"});
    dcyc = c0 + 3*S + 1 + k*P;
    q.push_back('{1, to ? 32'd1 : 32'd2, dcyc, to ? "R8 timeout outcome" : "R7 lock outcome (R6 sample time)"});
    lock_cyc = to ? NEVER : dcyc - 1;
    req_hz = hz; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !done && !locked && !timeout_error, "R10 flags cleared at start",
        {28'b0, busy, done, locked, timeout_error}, 32'h8);
    if (xoff >= 0) begin
      while (cyc < c0 + xoff - 1) @(negedge clk);
      req_hz = xhz; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (cyc < dcyc) @(negedge clk);
    chk(!busy && done, "R7 done and idle after run", {30'b0, busy, done}, 32'h1);
    lock_cyc = NEVER;
    repeat (4) @(negedge clk);
    chk(!busy, "R9 no restart after run", {31'b0, busy}, 32'h0);
  endtask

  task automatic ignored_req(input logic [31:0] hz, input string tag);
    @(negedge clk);
    req_hz = hz; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3*S + 5) @(negedge clk);
    chk(!busy && dll_cfg == img, tag, dll_cfg, img);
  endtask

  initial begin : watchdog
    repeat (200_000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (5) @(negedge clk);
    chk(dll_cfg == RST_IMG, "R1 reset image", dll_cfg, RST_IMG);
    chk(!busy && !done && !locked && !timeout_error, "R1 reset flags",
        {28'b0, busy, done, locked, timeout_error}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3-R7: first run locks on the first sample
    run_seq(32'd100_000_000, 0, 0, 32'd0, -1);
    // R2: threshold itself does not start
    ignored_req(32'd52_000_000, "R2 threshold request ignored");
    chk(done && locked, "R2 flags kept after ignored request", {30'b0, done, locked}, 32'h3);
    // R2: one above threshold starts, lock on fourth sample
    run_seq(32'd52_000_001, 3, 0, 32'd0, -1);
    ignored_req(32'd52_000_001, "R2 unchanged request ignored");
    // R9: request during run is dropped and not recorded
    run_seq(32'd120_000_000, 1, 0, 32'd150_000_000, S + 5);
    ignored_req(32'd120_000_000, "R9 busy request left record untouched");
    // R9: request on the finishing edge is dropped
    run_seq(32'd150_000_000, 0, 0, 32'd90_000_000, 3*S + 1);
    // R8: timeout with every other status bit set, then R9 record proof
    run_seq(32'd90_000_000, NP - 1, 1, 32'd0, -1);
    chk(timeout_error && !locked, "R8 timeout flags", {30'b0, locked, timeout_error}, 32'h1);
    // R8: lock on the very last sample wins over timeout
    run_seq(32'd70_000_000, NP - 1, 0, 32'd0, -1);
    chk(locked && !timeout_error, "R8 last-sample lock", {30'b0, locked, timeout_error}, 32'h2);

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R7 all expected events seen", 32'(q.size()), 32'h0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule